// File: doc/BRIEF.md
# DSP-Format Stereo Audio Serial Transmitter (Late Frame Start)

This block turns pairs of parallel stereo audio samples into one serial data line using a DSP-style frame with a late start. A faster system clock samples an external bit clock and a frame-sync signal; the block never generates either of them. Each frame starts at the bit-clock falling edge where the frame sync goes from low to high. On that edge the block drives the left-channel MSB. The rest of the left word follows, then the right word with no gap. After that the line stays low until the next frame sync.

New samples arrive on a valid strobe and are held in a staging stage. They only reach the shifter at a frame start, so a sample that changes in the middle of a frame never disturbs the frame being sent. The word length is chosen per frame from four settings. If a new frame sync arrives before both words have gone out, the block cuts the transfer short, starts the new frame and raises a sticky underrun flag.

Top module: `dsp_tx_top`

## Requirements
- R1: While `rst` is high, and on the first clock after it is released, `sd_out` and `underrun` are 0.
- R2: `sd_out` changes only at a `clk` edge where a bit-clock falling edge is seen. A falling edge is seen when `bclk` was 1 at the previous `clk` edge and is 0 at this one.
- R3: A frame starts at a bit-clock falling edge where `fsync` is 1 and was 0 at the previous `clk` edge. At that same edge, `sd_out` takes the left-channel MSB.
- R4: Each word is sent MSB first and is WL bits long. The word is the top WL bits of the 32-bit staged sample (bits 31 down to 32-WL). The left word is sent before the right word.
- R5: The right-word MSB is sent on the bit-clock falling edge right after the one that carried the left-word LSB.
- R6: After 2×WL bits, `sd_out` is 0 on every falling edge until the next frame start. It is also 0 before the first frame start after reset.
- R7: `wl_sel` selects WL as follows: 0 gives 16, 1 gives 20, 2 gives 24 and 3 gives 32. It is sampled only at a frame start, so a change in the middle of a frame has no effect on that frame.
- R8: A `clk` edge with `sample_valid` high stores `left_in` and `right_in`. The next frame start sends the stored values. Changes on `left_in` or `right_in` while `sample_valid` is low are ignored, and the last stored pair is sent again.
- R9: If a frame start arrives before 2×WL bits of the current frame have been sent, the current frame is dropped, the new frame starts normally, and `underrun` goes to 1 and stays there until reset.
- R10: A frame of exactly 2×WL bit clocks finishes cleanly, and the following frame start does not set `underrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk | input | 1 | External bit clock, sampled by `clk` |
| fsync | input | 1 | External frame sync, rises with a bit-clock fall |
| wl_sel | input | 2 | Word-length code (16/20/24/32) |
| left_in | input | MAX_W | Left sample, MSB-aligned |
| right_in | input | MAX_W | Right sample, MSB-aligned |
| sample_valid | input | 1 | Store `left_in`/`right_in` |
| sd_out | output | 1 | Serial data line |
| underrun | output | 1 | Sticky short-frame flag |

## Verification
The bench builds the block with MAX_W at its default of 32, so all four word-length codes can be tested, including the 32-bit case that fills a 64-bit frame exactly. Frames of 40, 48, 50, 64 and 40 bit clocks are run against matching word lengths. This covers frames with idle tails, a frame with no tail at all, and a frame too short for 32-bit words, which must truncate and raise `underrun`. The bench also updates the samples and changes the word-length code in the middle of a frame, and checks that these changes only take effect at the next frame.

// File: rtl/dsp_tx_pkg.sv
package dsp_tx_pkg;
  typedef enum logic [1:0] {
    WL_16 = 2'd0,
    WL_20 = 2'd1,
    WL_24 = 2'd2,
    WL_32 = 2'd3
  } wl_code_e;

  // Number of bits in one channel word for a given code.
  function automatic int unsigned word_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 20;
      2'd2:    return 24;
      default: return 32;
    endcase
  endfunction
endpackage

// File: rtl/dsp_tx_edges.sv
module dsp_tx_edges (
  input  logic clk,
  input  logic rst,
  input  logic bclk,
  input  logic fsync,
  output logic bit_tick,
  output logic frame_tick
);
  logic bclk_q;
  logic fs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_q <= 1'b0;
      fs_q   <= 1'b0;
    end else begin
      bclk_q <= bclk;
      fs_q   <= fsync;
    end
  end

  // R2: a falling edge of the bit clock, seen from the system clock
  assign bit_tick   = bclk_q & ~bclk;
  // R3: frame sync rising together with the bit-clock fall
  assign frame_tick = bit_tick & fsync & ~fs_q;
endmodule

// File: rtl/dsp_tx_stage.sv
module dsp_tx_stage #(
  parameter int MAX_W = 32,
  parameter int LEN_W = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sample_valid,
  input  logic [MAX_W-1:0]     left_in,
  input  logic [MAX_W-1:0]     right_in,
  input  logic [LEN_W-1:0]     word_len,
  output logic [2*MAX_W-1:0]   frame_word
);
  logic [MAX_W-1:0]   left_stg;
  logic [MAX_W-1:0]   right_stg;
  logic [2*MAX_W-1:0] right_wide;

  // R8: samples are stored only when strobed
  always_ff @(posedge clk) begin
    if (rst) begin
      left_stg  <= '0;
      right_stg <= '0;
    end else if (sample_valid) begin
      left_stg  <= left_in;
      right_stg <= right_in;
    end
  end

  // R4/R5: left word on top, right word packed directly below it
  always_comb begin
    right_wide = {right_stg, {MAX_W{1'b0}}} >> word_len;
    frame_word = ({left_stg, {MAX_W{1'b0}}} & ~({{MAX_W{1'b1}}, {MAX_W{1'b0}}} >> word_len))
               | right_wide;
  end
endmodule

// File: rtl/dsp_tx_shift.sv
module dsp_tx_shift
  import dsp_tx_pkg::*;
#(
  parameter int MAX_W = 32,
  parameter int CNT_W = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_tick,
  input  logic               frame_tick,
  input  logic [1:0]         wl_sel,
  input  logic [2*MAX_W-1:0] frame_word,
  output logic               sd_out,
  output logic               underrun
);
  localparam int FRAME_W = 2 * MAX_W;

  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]   sent;
  logic [CNT_W-1:0]   frame_len;
  logic [CNT_W-1:0]   next_len;

  assign next_len = CNT_W'(2 * word_bits(wl_sel));

  always_ff @(posedge clk) begin
    if (rst) begin
      sh        <= '0;
      sent      <= '1;
      frame_len <= '0;
      sd_out    <= 1'b0;
      underrun  <= 1'b0;
    end else if (frame_tick) begin
      // R9: earlier frame not finished
      if (sent < frame_len) underrun <= 1'b1;
      // R3/R7: load, latch the length, emit left MSB now
      sd_out    <= frame_word[FRAME_W-1];
      sh        <= frame_word << 1;
      sent      <= CNT_W'(1);
      frame_len <= next_len;
    end else if (bit_tick) begin
      if (sent < frame_len) begin
        sd_out <= sh[FRAME_W-1];
        sh     <= sh << 1;
        sent   <= sent + CNT_W'(1);
      end else begin
        sd_out <= 1'b0;  // R6: idle tail
      end
    end
  end
endmodule

// File: rtl/dsp_tx_top.sv
module dsp_tx_top
  import dsp_tx_pkg::*;
#(
  parameter int MAX_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bclk,
  input  logic             fsync,
  input  logic [1:0]       wl_sel,
  input  logic [MAX_W-1:0] left_in,
  input  logic [MAX_W-1:0] right_in,
  input  logic             sample_valid,
  output logic             sd_out,
  output logic             underrun
);
  localparam int CNT_W = $clog2(2 * MAX_W + 1);

  logic                 bit_tick;
  logic                 frame_tick;
  logic [2*MAX_W-1:0]   frame_word;
  logic [CNT_W-1:0]     word_len;

  assign word_len = CNT_W'(word_bits(wl_sel));

  dsp_tx_edges u_edges (
    .clk        (clk),
    .rst        (rst),
    .bclk       (bclk),
    .fsync      (fsync),
    .bit_tick   (bit_tick),
    .frame_tick (frame_tick)
  );

  dsp_tx_stage #(.MAX_W(MAX_W), .LEN_W(CNT_W)) u_stage (
    .clk          (clk),
    .rst          (rst),
    .sample_valid (sample_valid),
    .left_in      (left_in),
    .right_in     (right_in),
    .word_len     (word_len),
    .frame_word   (frame_word)
  );

  dsp_tx_shift #(.MAX_W(MAX_W), .CNT_W(CNT_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .bit_tick   (bit_tick),
    .frame_tick (frame_tick),
    .wl_sel     (wl_sel),
    .frame_word (frame_word),
    .sd_out     (sd_out),
    .underrun   (underrun)
  );
endmodule

// File: rtl/dsp_tx_checker.sv
module dsp_tx_checker (
  input logic clk,
  input logic rst,
  input logic bclk,
  input logic fsync,
  input logic sd_out,
  input logic underrun
);
  logic bclk_d, fs_d, fall_prev, start_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_d     <= 1'b0;
      fs_d       <= 1'b0;
      fall_prev  <= 1'b0;
      start_prev <= 1'b0;
    end else begin
      bclk_d     <= bclk;
      fs_d       <= fsync;
      fall_prev  <= bclk_d & ~bclk;
      start_prev <= bclk_d & ~bclk & fsync & ~fs_d;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!sd_out && !underrun));

  assert_hold_between_falls_R2: assert property (@(posedge clk) disable iff (rst)
    !fall_prev |-> $stable(sd_out));

  assert_sticky_underrun_R9: assert property (@(posedge clk) disable iff (rst)
    underrun |=> underrun);

  assert_underrun_at_frame_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(underrun) |-> start_prev);
endmodule

bind dsp_tx_top dsp_tx_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .bclk     (bclk),
  .fsync    (fsync),
  .sd_out   (sd_out),
  .underrun (underrun)
);

// File: tb/dsp_tx_top_bench.sv
module dsp_tx_top_bench;
  localparam int CLK_P = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bclk = 1'b0;
  logic         fsync = 1'b0;
  logic [1:0]   wl_sel = 2'd0;
  logic [W-1:0] left_in = '0;
  logic [W-1:0] right_in = '0;
  logic         sample_valid = 1'b0;
  logic         sd_out;
  logic         underrun;

  int tests = 0;
  int fails = 0;
  string cur_req = "R1";

  always #(CLK_P/2) clk = ~clk;

  dsp_tx_top #(.MAX_W(W)) u_dsp_tx_top (
    .clk(clk), .rst(rst), .bclk(bclk), .fsync(fsync), .wl_sel(wl_sel),
    .left_in(left_in), .right_in(right_in), .sample_valid(sample_valid),
    .sd_out(sd_out), .underrun(underrun)
  );

  // Behavioural reference model
  bit         m_bq, m_fq, exp_sd, exp_ur;
  bit [W-1:0] m_l, m_r;
  bit         bitq[$];

  function automatic int len_of(input logic [1:0] c);
    return (c == 2'd0) ? 16 : (c == 2'd1) ? 20 : (c == 2'd2) ? 24 : 32;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_bq = 0; m_fq = 0; exp_sd = 0; exp_ur = 0; m_l = '0; m_r = '0;
      bitq.delete();
    end else begin
      if (m_bq && !bclk) begin
        if (fsync && !m_fq) begin
          if (bitq.size() > 0) exp_ur = 1;
          bitq.delete();
          for (int i = 0; i < len_of(wl_sel); i++) bitq.push_back(m_l[W-1-i]);
          for (int i = 0; i < len_of(wl_sel); i++) bitq.push_back(m_r[W-1-i]);
        end
        exp_sd = (bitq.size() > 0) ? bitq.pop_front() : 1'b0;
      end
      if (sample_valid) begin m_l = left_in; m_r = right_in; end
      m_bq = bclk; m_fq = fsync;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      tests++;
      if (sd_out !== exp_sd) begin
        fails++;
        $display("FAIL %s sd_out actual=%0b expected=%0b t=%0t", cur_req, sd_out, exp_sd, $time);
      end
      tests++;
      if (underrun !== exp_ur) begin
        fails++;
        $display("FAIL %s underrun actual=%0b expected=%0b t=%0t", cur_req, underrun, exp_ur, $time);
      end
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic load(input logic [W-1:0] l, input logic [W-1:0] r);
    @(negedge clk);
    left_in = l; right_in = r; sample_valid = 1'b1;
    @(negedge clk);
    sample_valid = 1'b0;
  endtask

  task automatic one_bit(input logic fs);
    @(negedge clk); bclk = 1'b1;
    @(negedge clk);
    @(negedge clk); bclk = 1'b0; fsync = fs;
    @(negedge clk);
  endtask

  // Frame of nbits bit clocks; optional mid-frame update at bit upd_at
  task automatic frame(input int nbits, input int upd_at,
                       input logic [W-1:0] nl, input logic [W-1:0] nr, input logic [1:0] nwl);
    one_bit(1'b1);
    for (int i = 1; i < nbits; i++) begin
      if (i == upd_at) begin
        load(nl, nr);
        wl_sel = nwl;
        left_in = ~nl;  // ignored without strobe (R8)
      end
      one_bit(1'b0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", sd_out, 1'b0);
    check("R1", underrun, 1'b0);
    @(negedge clk); rst = 1'b0;
    check("R1", sd_out, 1'b0);
    cur_req = "R6";
    repeat (3) one_bit(1'b0);
    check("R6", sd_out, 1'b0);

    cur_req = "R4";
    wl_sel = 2'd0;
    load(32'hA5C3_1234, 32'h5A3C_8765);
    left_in = 32'hFFFF_FFFF;  // R8: no strobe, ignored
    frame(40, -1, '0, '0, 2'd0);
    cur_req = "R5";
    frame(40, -1, '0, '0, 2'd0);

    cur_req = "R7";
    wl_sel = 2'd1;
    load(32'hF0E1_D2C3, 32'h0F1E_2D3C);
    frame(48, 10, 32'h1357_9BDF, 32'h2468_ACE0, 2'd2);
    cur_req = "R8";
    frame(50, -1, '0, '0, 2'd2);

    cur_req = "R10";
    wl_sel = 2'd3;
    load(32'h8000_0001, 32'hC0FF_EE11);
    frame(64, -1, '0, '0, 2'd3);
    frame(64, -1, '0, '0, 2'd3);
    check("R10", underrun, 1'b0);

    cur_req = "R9";
    frame(40, -1, '0, '0, 2'd3);
    frame(64, -1, '0, '0, 2'd3);
    check("R9", underrun, 1'b1);
    cur_req = "R3";
    wl_sel = 2'd0;
    frame(40, -1, '0, '0, 2'd0);
    one_bit(1'b0);
    check("R9", underrun, 1'b1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule